// File: doc/BRIEF.md
# Thermistor Conductance Tracker with Thermal Derating

This block keeps an external thermistor network at a fixed sense voltage and reads the result as a conductance code. The code sets an off-chip current source that feeds the network. An off-chip comparator reports whether the sense pin is above or below the reference. On every sample tick the block moves the code one step, so that the pin voltage hovers around the reference. A hotter negative-coefficient thermistor has a lower resistance and needs more current, so a larger code means a higher temperature. One code step is the conductance of a single 4 MΩ resistor, and 256 steps is about 15.6 kΩ.

The raw code feeds two first-order low-pass filters. The fast filter drives a thermal shutdown flag with hysteresis. The flag is not latched: tracking goes on while it is set, and it clears once the network has cooled. The slow filter drives a scale factor for the dim level. The scale is 1.0 at the derating start point (about 95 °C) and falls in a straight line to 0.5 at the shutdown point (about 125 °C). A ready flag holds back the rest of the system after reset. It rises only after a settling window has passed and the fast-filtered code has shown the network to be below the resume temperature.

Top module: `ntc_derate_tracker`

## Requirements
- R1: While reset is high and on the first cycle after it, `code` is 0, `scale` is 256 (1.0), `shutdown` is 0 and `ready` is 0. `code` never leaves the range 0..256.
- R2: On a clock edge with `tick` high, `code` falls by 1 when `pin_above` is 1 (pin above the reference) and rises by 1 when `pin_above` is 0. It holds at 0 and at 256 instead of wrapping.
- R3: On an edge with `tick` low, `code` and both filter states are unchanged.
- R4: Each filter keeps an accumulator with 8 fractional bits. On a tick, with the target equal to the current code times 256, the accumulator moves toward the target by |target−acc| >> SHIFT, rounded down. SHIFT is 2 for the fast filter and 5 for the slow filter. The filtered code is acc >> 8.
- R5: On the edge after the slow filtered code s is seen, `scale` becomes: 256 if s ≤ 197; 128 if s ≥ 241; otherwise 256 − (((s−197)·11915 + 2048) >> 12). Here 11915 = ⌊128·4096/44⌋. The result always lies in 128..256.
- R6: `shutdown` sets on the edge after the fast filtered code is ≥ 241 and clears on the edge after it is < 208. Between those values it holds.
- R7: A settle counter counts ticks after reset up to 320. `ready` rises on the edge after the counter has reached 320 while the fast filtered code is < 208. Once set, `ready` stays 1 until reset.
- R8: The servo keeps tracking while `shutdown` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe, one clock wide |
| pin_above | input | 1 | Comparator: sense pin above reference |
| code | output | 9 | Conductance code for the current source (0..256) |
| scale | output | 9 | Dim scale, 256 = 1.0, 128 = 0.5 |
| shutdown | output | 1 | Thermal shutdown request, non-latched |
| ready | output | 1 | Startup temperature gate passed |

## Verification
Two updates can land on the same edge. When the network is slewed hot, the fast filter can cross the shutdown code on an edge where the slow filter is still moving the scale. When tracking slews down, a shutdown release can coincide with the first edge on which the settle counter allows `ready`. The bench provokes both with a hot start followed by step changes in the modelled network resistance. A behavioural model predicts every output on every cycle, so any mismatch in the ordering of the two updates is reported on the edge where it occurs.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  localparam int unsigned NTC_CODE_W   = 9;
  localparam int unsigned NTC_CODE_MAX = 256;
  localparam int unsigned NTC_FRAC     = 8;
  localparam int unsigned NTC_SCALE_W  = 9;
  localparam int unsigned NTC_QB       = 12;
endpackage

// File: rtl/ntc_servo.sv
module ntc_servo #(
  parameter int unsigned CODE_W   = ntc_pkg::NTC_CODE_W,
  parameter int unsigned CODE_MAX = ntc_pkg::NTC_CODE_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              above,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(CODE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
    end else if (tick) begin
      if (above) begin
        if (code != '0) code <= code - 1'b1;
      end else begin
        if (code != TOP) code <= code + 1'b1;
      end
    end
  end

  assert_range_R1: assert property (@(posedge clk) disable iff (rst)
    code <= TOP);
  assert_down_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && above && code != '0) |=> (code == $past(code) - 1'b1));
  assert_up_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !above && code != TOP) |=> (code == $past(code) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(code));
endmodule

// File: rtl/ntc_iir.sv
module ntc_iir #(
  parameter int unsigned CODE_W   = ntc_pkg::NTC_CODE_W,
  parameter int unsigned CODE_MAX = ntc_pkg::NTC_CODE_MAX,
  parameter int unsigned FRAC     = ntc_pkg::NTC_FRAC,
  parameter int unsigned SHIFT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] filt
);
  localparam int unsigned AW = CODE_W + FRAC;
  localparam logic [CODE_W-1:0] TOP = CODE_W'(CODE_MAX);

  logic [AW-1:0] acc, tgt, diff;
  logic          rising;

  assign tgt    = {code, {FRAC{1'b0}}};
  assign rising = (tgt >= acc);
  assign diff   = rising ? (tgt - acc) : (acc - tgt);
  assign filt   = acc[AW-1:FRAC];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (tick) begin
      if (rising) acc <= acc + (diff >> SHIFT);
      else        acc <= acc - (diff >> SHIFT);
    end
  end

  assert_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    filt <= TOP);
  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(acc));
endmodule

// File: rtl/ntc_guard.sv
module ntc_guard #(
  parameter int unsigned CODE_W       = ntc_pkg::NTC_CODE_W,
  parameter int unsigned SCALE_W      = ntc_pkg::NTC_SCALE_W,
  parameter int unsigned QB           = ntc_pkg::NTC_QB,
  parameter int unsigned DERATE_CODE  = 197,
  parameter int unsigned SHUT_CODE    = 241,
  parameter int unsigned RESUME_CODE  = 208,
  parameter int unsigned SETTLE_TICKS = 320
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [CODE_W-1:0]  fast,
  input  logic [CODE_W-1:0]  slow,
  output logic [SCALE_W-1:0] scale,
  output logic               shutdown,
  output logic               ready
);
  localparam int unsigned ONE   = 1 << (SCALE_W - 1);
  localparam int unsigned HALF  = ONE / 2;
  localparam int unsigned SPAN  = SHUT_CODE - DERATE_CODE;
  localparam int unsigned SLOPE = (HALF << QB) / SPAN;
  localparam int unsigned RND   = 1 << (QB - 1);
  localparam int unsigned CW    = $clog2(SETTLE_TICKS + 1);
  localparam logic [CODE_W-1:0]  DER_C = CODE_W'(DERATE_CODE);
  localparam logic [CODE_W-1:0]  SHT_C = CODE_W'(SHUT_CODE);
  localparam logic [CODE_W-1:0]  RES_C = CODE_W'(RESUME_CODE);
  localparam logic [CW-1:0]      SET_C = CW'(SETTLE_TICKS);
  localparam logic [SCALE_W-1:0] ONE_C = SCALE_W'(ONE);
  localparam logic [SCALE_W-1:0] HLF_C = SCALE_W'(HALF);

  logic [CW-1:0]      cnt;
  logic [31:0]        prod;
  logic [SCALE_W-1:0] scale_c;

  always_comb begin
    prod = 32'(slow - DER_C) * SLOPE + RND;
    if (slow <= DER_C)      scale_c = ONE_C;
    else if (slow >= SHT_C) scale_c = HLF_C;
    else                    scale_c = SCALE_W'(ONE - (prod >> QB));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      shutdown <= 1'b0;
      ready    <= 1'b0;
      scale    <= ONE_C;
    end else begin
      if (tick && cnt != SET_C) cnt <= cnt + 1'b1;
      if (fast >= SHT_C)      shutdown <= 1'b1;
      else if (fast < RES_C)  shutdown <= 1'b0;
      if (cnt == SET_C && fast < RES_C) ready <= 1'b1;
      scale <= scale_c;
    end
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(fast) < RES_C));
  assert_trip_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown) |-> ($past(fast) >= SHT_C));
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(shutdown) |-> ($past(fast) < RES_C));
  assert_scale_span_R5: assert property (@(posedge clk) disable iff (rst)
    (scale >= HLF_C) && (scale <= ONE_C));
endmodule

// File: rtl/ntc_derate_tracker.sv
module ntc_derate_tracker #(
  parameter int unsigned CODE_W       = ntc_pkg::NTC_CODE_W,
  parameter int unsigned CODE_MAX     = ntc_pkg::NTC_CODE_MAX,
  parameter int unsigned FRAC         = ntc_pkg::NTC_FRAC,
  parameter int unsigned SCALE_W      = ntc_pkg::NTC_SCALE_W,
  parameter int unsigned FAST_SHIFT   = 2,
  parameter int unsigned SLOW_SHIFT   = 5,
  parameter int unsigned DERATE_CODE  = 197,
  parameter int unsigned SHUT_CODE    = 241,
  parameter int unsigned RESUME_CODE  = 208,
  parameter int unsigned SETTLE_TICKS = 320
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               pin_above,
  output logic [CODE_W-1:0]  code,
  output logic [SCALE_W-1:0] scale,
  output logic               shutdown,
  output logic               ready
);
  logic [CODE_W-1:0] filt [2];

  ntc_servo #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_servo (
    .clk(clk), .rst(rst), .tick(tick), .above(pin_above), .code(code)
  );

  for (genvar g = 0; g < 2; g++) begin : g_filt
    localparam int unsigned SH = (g == 0) ? FAST_SHIFT : SLOW_SHIFT;
    ntc_iir #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .FRAC(FRAC), .SHIFT(SH)) u_iir (
      .clk(clk), .rst(rst), .tick(tick), .code(code), .filt(filt[g])
    );
  end

  ntc_guard #(
    .CODE_W(CODE_W), .SCALE_W(SCALE_W), .DERATE_CODE(DERATE_CODE),
    .SHUT_CODE(SHUT_CODE), .RESUME_CODE(RESUME_CODE), .SETTLE_TICKS(SETTLE_TICKS)
  ) u_guard (
    .clk(clk), .rst(rst), .tick(tick), .fast(filt[0]), .slow(filt[1]),
    .scale(scale), .shutdown(shutdown), .ready(ready)
  );
endmodule

// File: tb/ntc_derate_tracker_test.sv
module ntc_derate_tracker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic pin_above = 1'b0;
  logic [8:0] code, scale;
  logic shutdown, ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  // model state
  int m_code, m_fast, m_slow, m_cnt, m_scale;
  bit m_shut, m_ready;
  localparam int SLOPE = (128 * 4096) / 44;

  always #2.5 clk = ~clk;

  ntc_derate_tracker uut (
    .clk(clk), .rst(rst), .tick(tick), .pin_above(pin_above),
    .code(code), .scale(scale), .shutdown(shutdown), .ready(ready)
  );

  function automatic int iir(int acc, int c, int sh);
    int t = c * 256;
    if (t >= acc) return acc + ((t - acc) >> sh);
    return acc - ((acc - t) >> sh);
  endfunction

  function automatic int scale_of(int s);
    if (s <= 197) return 256;
    if (s >= 241) return 128;
    return 256 - (((s - 197) * SLOPE + 2048) >> 12);
  endfunction

  always @(posedge clk) begin
    int fo, so, nc;
    if (rst) begin
      m_code = 0; m_fast = 0; m_slow = 0; m_cnt = 0;
      m_scale = 256; m_shut = 0; m_ready = 0;
    end else begin
      fo = m_fast >> 8;
      so = m_slow >> 8;
      nc = m_code;
      if (tick) begin
        if (pin_above) nc = (m_code > 0) ? m_code - 1 : 0;
        else           nc = (m_code < 256) ? m_code + 1 : 256;
        m_fast = iir(m_fast, m_code, 2);
        m_slow = iir(m_slow, m_code, 5);
      end
      if (m_cnt == 320 && fo < 208) m_ready = 1;
      if (tick && m_cnt < 320) m_cnt++;
      if (fo >= 241)     m_shut = 1;
      else if (fo < 208) m_shut = 0;
      m_scale = scale_of(so);
      m_code = nc;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check(int'(code) == m_code, "R2 code", int'(code), m_code);
    check(int'(scale) == m_scale, "R5 scale", int'(scale), m_scale);
    check(shutdown == m_shut, "R6 shutdown", int'(shutdown), int'(m_shut));
    check(ready == m_ready, "R7 ready", int'(ready), int'(m_ready));
  endtask

  // mode: 0 = resistor model, 1 = force above, 2 = force below
  task automatic phase(int cycles, int res, int mode, bit tick_on);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cmp_on) compare_all();
      tick = tick_on && (i % 4 == 0);
      if (mode == 1)      pin_above = 1'b1;
      else if (mode == 2) pin_above = 1'b0;
      else                pin_above = (int'(code) * res >= 4000000);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int held;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(code == 9'd0, "R1 reset code", int'(code), 0);
    check(scale == 9'd256, "R1 reset scale", int'(scale), 256);
    check(shutdown == 1'b0, "R1 reset shutdown", int'(shutdown), 0);
    check(ready == 1'b0, "R1 reset ready", int'(ready), 0);
    rst = 1'b0;
    cmp_on = 1;
    // hot start: settle window passes but gate must stay closed
    phase(1600, 16000, 0, 1);
    check(ready == 1'b0, "R7 hot start gate held", int'(ready), 0);
    check(shutdown == 1'b1, "R6 trip at hot", int'(shutdown), 1);
    check(code >= 9'd240, "R2 tracks hot network", int'(code), 250);
    // partial cool into hysteresis band: tracking continues, trip holds
    phase(400, 18000, 0, 1);
    check(code < 9'd235, "R8 tracking during shutdown", int'(code), 222);
    check(shutdown == 1'b1, "R6 hold in band", int'(shutdown), 1);
    // cool below resume
    phase(600, 25000, 0, 1);
    check(shutdown == 1'b0, "R6 release", int'(shutdown), 0);
    check(ready == 1'b1, "R7 gate opens", int'(ready), 1);
    // no ticks: code frozen
    held = int'(code);
    phase(100, 100000, 0, 0);
    check(int'(code) == held, "R3 no tick hold", int'(code), held);
    // cold: full scale
    phase(2000, 100000, 0, 1);
    check(scale == 9'd256, "R5 cold full scale", int'(scale), 256);
    // mid derating
    phase(2000, 19000, 0, 1);
    check(scale > 9'd128 && scale < 9'd256, "R5 mid derate", int'(scale), m_scale);
    check(shutdown == 1'b0, "R6 mid no trip", int'(shutdown), 0);
    // saturate high
    phase(2400, 0, 2, 1);
    check(code == 9'd256, "R2 saturate top", int'(code), 256);
    check(scale == 9'd128, "R5 floor scale", int'(scale), 128);
    check(shutdown == 1'b1, "R6 trip at top", int'(shutdown), 1);
    // saturate low
    phase(2400, 0, 1, 1);
    check(code == 9'd0, "R1 saturate bottom", int'(code), 0);
    check(ready == 1'b1, "R7 ready sticky", int'(ready), 1);
    check(shutdown == 1'b0, "R6 release at bottom", int'(shutdown), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule